// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block is the integer multiply and divide engine that sits beside a 32-bit core's pipeline. A one-cycle start pulse hands it two operands, an operation select and a signed/unsigned select. It then works one bit per cycle for 32 cycles. A multiply builds the full 64-bit product. A divide builds a quotient and a remainder. The results land in two dedicated registers, HI and LO, that the block owns.

The core reads HI or LO through a read port. The read port carries a ready signal that stays low while an operation runs, so a read issued too early stalls. The core can also load either register directly when the unit is idle. Two status flags report on the most recent operation. The overflow flag says whether a multiply's product did not fit in 32 bits. The divide-by-zero flag says whether a divide had a zero divisor. No trap is raised: turning a flag into an exception is left to the core.

Top module: `muldiv_unit`

## Requirements
- R1: A multiply (`op_i`=0) writes the low 32 bits of the 64-bit product to LO and the high 32 bits to HI. With `signed_i`=1 the operands are two's complement; with `signed_i`=0 they are unsigned.
- R2: An unsigned divide (`op_i`=1, `signed_i`=0) writes the quotient to LO and the remainder to HI, with both operands taken as unsigned.
- R3: A signed divide truncates the quotient toward zero, and the remainder takes the dividend's sign. The case -2^31 / -1 gives LO=0x80000000 and HI=0.
- R4: When a multiply finishes, `ovf_o` is 1 exactly when the product does not fit in 32 bits. For the signed form that means HI is not the sign extension of LO; for the unsigned form it means HI is nonzero. A divide clears `ovf_o`.
- R5: A divide with a zero divisor takes the normal 32 cycles and sets `dz_o` to 1. The values it leaves in HI/LO are defined but carry no meaning. Any other finished operation clears `dz_o`.
- R6: A start accepted at a clock edge makes `busy_o` high for exactly the next 32 cycles. HI, LO and the flags update at the 32nd edge, and `done_o` is high for the single cycle after that edge.
- R7: `rd_ready_o` is 0 while `busy_o` is 1. When `rd_ready_o` is 1, `rd_data_o` shows LO for `rd_sel_i`=0 and HI for `rd_sel_i`=1.
- R8: A `start_i` raised while `busy_o` is 1 is ignored. It neither restarts the count nor changes the operands already taken.
- R9: When the unit is idle, `mt_en_i`=1 loads `mt_data_i` into LO (`mt_sel_i`=0) or HI (`mt_sel_i`=1) at the clock edge. A load requested while `busy_o` is 1 is ignored.
- R10: A synchronous active-high `rst` clears HI, LO, `busy_o`, `done_o`, `ovf_o` and `dz_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; taken only when idle |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| signed_i | input | 1 | 1 = two's complement operands |
| a_i | input | 32 | Multiplicand / dividend |
| b_i | input | 32 | Multiplier / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after results are written |
| ovf_o | output | 1 | Last multiply's product exceeded 32 bits |
| dz_o | output | 1 | Last divide had a zero divisor |
| mt_en_i | input | 1 | Load request for HI or LO |
| mt_sel_i | input | 1 | Load target: 0 = LO, 1 = HI |
| mt_data_i | input | 32 | Load data |
| rd_sel_i | input | 1 | Read select: 0 = LO, 1 = HI |
| rd_data_o | output | 32 | Selected register contents |
| rd_ready_o | output | 1 | Read data valid (unit idle) |

## Verification
The bench targets the sign corner cases. Signed divides with mixed-sign operands expose a floored quotient or a remainder that takes the divisor's sign, because those give -4/1 instead of -3/-1 for -7/2. The -2^31 / -1 and -2^31 × -2^31 cases expose magnitude logic that loses the top bit.

For overflow, the bench uses products that sit exactly on the edge, such as -65536 × 32768. A check that looks only at HI being nonzero would wrongly flag these signed results. Zero divisors confirm that the unit finishes on time instead of hanging.

Start pulses and HI/LO loads fired in the middle of a busy window expose a unit that restarts or corrupts its results. Ready is compared on every cycle, so a read port that releases data early is caught.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int DATA_W = 32;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } hilo_sel_e;

endpackage

// File: rtl/muldiv_engine.sv
module muldiv_engine
    import muldiv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  md_op_e       op_i,
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         res_we_o,
    output logic [W-1:0] res_hi_o,
    output logic [W-1:0] res_lo_o,
    output logic         ovf_o,
    output logic         dz_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS = CW'(W);

    logic [CW-1:0] cnt_q;
    md_op_e        op_q;
    logic          sgn_q, neg_main_q, neg_rem_q;
    logic [W-1:0]  mop_q, hi_q, lo_q;
    logic          done_q, ovf_q, dz_q;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic s);
        return (s && x[W-1]) ? (~x + 1'b1) : x;
    endfunction

    // one shift-add step
    logic [W:0]   mul_sum;
    logic [W-1:0] mul_hi_n, mul_lo_n;
    // one restoring-divide step
    logic [W:0]   div_r, div_diff;
    logic         div_ge;
    logic [W-1:0] div_hi_n, div_lo_n;
    // final values
    logic [2*W-1:0] prod_mag, prod;
    logic [W-1:0]   quo, rem;
    logic           last, ovf_calc, dz_calc;

    always_comb begin
        mul_sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mop_q} : '0);
        mul_hi_n = mul_sum[W:1];
        mul_lo_n = {mul_sum[0], lo_q[W-1:1]};

        div_r    = {hi_q, lo_q[W-1]};
        div_ge   = (div_r >= {1'b0, mop_q});
        div_diff = div_r - {1'b0, mop_q};
        div_hi_n = div_ge ? div_diff[W-1:0] : div_r[W-1:0];
        div_lo_n = {lo_q[W-2:0], div_ge};

        prod_mag = {mul_hi_n, mul_lo_n};
        prod     = neg_main_q ? (~prod_mag + 1'b1) : prod_mag;
        quo      = neg_main_q ? (~div_lo_n + 1'b1) : div_lo_n;
        rem      = neg_rem_q  ? (~div_hi_n + 1'b1) : div_hi_n;

        if (sgn_q) ovf_calc = (prod[2*W-1:W] != {W{prod[W-1]}});
        else       ovf_calc = (prod[2*W-1:W] != '0);
        dz_calc  = (mop_q == '0);
        last     = (cnt_q == CW'(1));
    end

    assign busy_o   = (cnt_q != '0);
    assign res_we_o = busy_o && last;
    assign res_hi_o = (op_q == OP_MUL) ? prod[2*W-1:W] : rem;
    assign res_lo_o = (op_q == OP_MUL) ? prod[W-1:0]   : quo;
    assign done_o   = done_q;
    assign ovf_o    = ovf_q;
    assign dz_o     = dz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            op_q       <= OP_MUL;
            sgn_q      <= 1'b0;
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
            mop_q      <= '0;
            hi_q       <= '0;
            lo_q       <= '0;
            done_q     <= 1'b0;
            ovf_q      <= 1'b0;
            dz_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    cnt_q      <= STEPS;
                    op_q       <= op_i;
                    sgn_q      <= signed_i;
                    neg_main_q <= signed_i && (a_i[W-1] ^ b_i[W-1]);
                    neg_rem_q  <= signed_i && a_i[W-1];
                    hi_q       <= '0;
                    if (op_i == OP_MUL) begin
                        lo_q  <= magnitude(b_i, signed_i);
                        mop_q <= magnitude(a_i, signed_i);
                    end else begin
                        lo_q  <= magnitude(a_i, signed_i);
                        mop_q <= magnitude(b_i, signed_i);
                    end
                end
            end else begin
                cnt_q <= cnt_q - CW'(1);
                hi_q  <= (op_q == OP_MUL) ? mul_hi_n : div_hi_n;
                lo_q  <= (op_q == OP_MUL) ? mul_lo_n : div_lo_n;
                if (last) begin
                    done_q <= 1'b1;
                    ovf_q  <= (op_q == OP_MUL) && ovf_calc;
                    dz_q   <= (op_q == OP_DIV) && dz_calc;
                end
            end
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));  // R8
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));  // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);  // R6
    AST_DZ_FLAG: assert property (@(posedge clk) disable iff (rst)
        (res_we_o && op_q == OP_DIV && mop_q == '0) |=> (dz_o && !ovf_o));  // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (res_we_o && op_q == OP_MUL && !sgn_q && res_hi_o == '0) |=> !ovf_o);  // R4

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         res_we_i,
    input  logic [W-1:0] res_hi_i,
    input  logic [W-1:0] res_lo_i,
    input  logic         mt_we_i,
    input  hilo_sel_e    mt_sel_i,
    input  logic [W-1:0] mt_data_i,
    input  hilo_sel_e    rd_sel_i,
    output logic [W-1:0] rd_data_o
);
    logic [W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (res_we_i) begin
            hi_q <= res_hi_i;
            lo_q <= res_lo_i;
        end else if (mt_we_i) begin
            if (mt_sel_i == SEL_HI) hi_q <= mt_data_i;
            else                    lo_q <= mt_data_i;
        end
    end

    assign rd_data_o = (rd_sel_i == SEL_HI) ? hi_q : lo_q;

    AST_HOLD_REGS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(res_we_i) && !$past(mt_we_i)) |-> ($stable(hi_q) && $stable(lo_q)));  // R9

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        op_i,
    input  logic        signed_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        ovf_o,
    output logic        dz_o,
    input  logic        mt_en_i,
    input  logic        mt_sel_i,
    input  logic [31:0] mt_data_i,
    input  logic        rd_sel_i,
    output logic [31:0] rd_data_o,
    output logic        rd_ready_o
);
    localparam int W = DATA_W;

    logic         res_we;
    logic [W-1:0] res_hi, res_lo;
    logic         mt_we;

    muldiv_engine #(.W(W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (md_op_e'(op_i)),
        .signed_i (signed_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .res_we_o (res_we),
        .res_hi_o (res_hi),
        .res_lo_o (res_lo),
        .ovf_o    (ovf_o),
        .dz_o     (dz_o)
    );

    assign mt_we      = mt_en_i && !busy_o;
    assign rd_ready_o = !busy_o;

    muldiv_hilo #(.W(W)) u_hilo (
        .clk       (clk),
        .rst       (rst),
        .res_we_i  (res_we),
        .res_hi_i  (res_hi),
        .res_lo_i  (res_lo),
        .mt_we_i   (mt_we),
        .mt_sel_i  (hilo_sel_e'(mt_sel_i)),
        .mt_data_i (mt_data_i),
        .rd_sel_i  (hilo_sel_e'(rd_sel_i)),
        .rd_data_o (rd_data_o)
    );

    AST_READ_STALL: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !rd_ready_o);  // R7

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, op_i = 1'b0, signed_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        busy_o, done_o, ovf_o, dz_o;
    logic        mt_en_i = 1'b0, mt_sel_i = 1'b0;
    logic [31:0] mt_data_i = '0;
    logic        rd_sel_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        rd_ready_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    muldiv_unit u_dut (.*);

    // reference model state
    int          m_cnt = 0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic        m_hv = 1'b1, m_lv = 1'b1;
    logic        m_ovf = 1'b0, m_dz = 1'b0, m_done = 1'b0;
    string       m_htag = "R10", m_ltag = "R10";
    logic [31:0] p_hi, p_lo;
    logic        p_ovf, p_dz;
    string       p_tag;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic predict(logic op, logic sgn, logic [31:0] a, logic [31:0] b);
        longint            sp, sa, sb, q, r;
        longint unsigned   up;
        p_ovf = 1'b0;
        p_dz  = 1'b0;
        if (!op) begin
            p_tag = "R1";
            if (sgn) begin
                sp = longint'($signed(a)) * longint'($signed(b));
                p_hi = sp[63:32];
                p_lo = sp[31:0];
                p_ovf = (sp > 64'sd2147483647) || (sp < -64'sd2147483648);
            end else begin
                up = {32'd0, a} * {32'd0, b};
                p_hi = up[63:32];
                p_lo = up[31:0];
                p_ovf = (up[63:32] != 0);
            end
            if (p_ovf) p_tag = "R4";
        end else if (b == 0) begin
            p_tag = "R5";
            p_dz = 1'b1;
            p_hi = '0;
            p_lo = '0;
        end else if (sgn) begin
            p_tag = "R3";
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = sa / sb;
            r = sa % sb;
            p_lo = q[31:0];
            p_hi = r[31:0];
        end else begin
            p_tag = "R2";
            p_lo = a / b;
            p_hi = a % b;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_hi = '0; m_lo = '0; m_hv = 1; m_lv = 1;
            m_ovf = 0; m_dz = 0; m_done = 0; m_htag = "R10"; m_ltag = "R10";
        end else begin
            m_done = 1'b0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    m_hi = p_hi; m_lo = p_lo;
                    m_hv = !p_dz; m_lv = !p_dz;
                    m_ovf = p_ovf; m_dz = p_dz;
                    m_htag = p_tag; m_ltag = p_tag;
                end
            end else begin
                if (mt_en_i) begin
                    if (mt_sel_i) begin m_hi = mt_data_i; m_hv = 1; m_htag = "R9"; end
                    else          begin m_lo = mt_data_i; m_lv = 1; m_ltag = "R9"; end
                end
                if (start_i) begin
                    predict(op_i, signed_i, a_i, b_i);
                    m_cnt = 32;
                end
            end
        end
        #5;
        chk("R6", "busy", {31'd0, busy_o}, {31'd0, m_cnt != 0});
        chk("R6", "done", {31'd0, done_o}, {31'd0, m_done});
        chk("R7", "ready", {31'd0, rd_ready_o}, {31'd0, m_cnt == 0});
        chk("R4", "ovf", {31'd0, ovf_o}, {31'd0, m_ovf});
        chk("R5", "dz", {31'd0, dz_o}, {31'd0, m_dz});
        if (rd_ready_o && m_cnt == 0) begin
            if (rd_sel_i && m_hv)       chk(m_htag, "HI", rd_data_o, m_hi);
            else if (!rd_sel_i && m_lv) chk(m_ltag, "LO", rd_data_o, m_lo);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) rd_sel_i <= ~rd_sel_i;

    task automatic run_op(logic op, logic sgn, logic [31:0] a, logic [31:0] b, bit disturb);
        @(negedge clk);
        start_i = 1; op_i = op; signed_i = sgn; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 33; i++) begin
            if (disturb && i == 5) begin  // R8 and R9: ignored while busy
                start_i = 1; op_i = ~op; a_i = 32'h1234_5678; b_i = 32'h0000_0003;
                mt_en_i = 1; mt_sel_i = 1; mt_data_i = 32'hDEAD_BEEF;
            end else begin
                start_i = 0; mt_en_i = 0;
            end
            @(negedge clk);
        end
        start_i = 0; mt_en_i = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic move_to(logic sel, logic [31:0] d);
        @(negedge clk);
        mt_en_i = 1; mt_sel_i = sel; mt_data_i = d;
        @(negedge clk);
        mt_en_i = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);          // R10 reset contents checked by model
        run_op(0, 0, 32'd7, 32'd9, 0);                  // R1
        run_op(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);  // R4 R8
        run_op(0, 1, -32'sd3, 32'sd5, 0);               // R1 signed
        run_op(0, 1, 32'h8000_0000, 32'h8000_0000, 0);  // R4 signed
        run_op(0, 1, -32'sd65536, 32'sd32768, 0);       // R4 edge, fits
        run_op(0, 0, 32'h0001_0000, 32'h0001_0000, 0);  // R4 unsigned
        run_op(1, 0, 32'd100, 32'd7, 1);                // R2 R8
        run_op(1, 0, 32'hFFFF_FFFF, 32'd3, 0);          // R2
        run_op(1, 1, -32'sd7, 32'sd2, 0);               // R3
        run_op(1, 1, 32'sd7, -32'sd2, 0);               // R3
        run_op(1, 1, -32'sd7, -32'sd2, 0);              // R3
        run_op(1, 1, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R3 corner
        run_op(1, 0, 32'd5, 32'd0, 0);                  // R5
        move_to(1, 32'hCAFE_0001);                      // R9
        move_to(0, 32'h0BAD_F00D);                      // R9
        run_op(0, 0, 32'd3, 32'd4, 1);                  // clears dz, R9 ignore
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);                      // R10 again
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule